// File: doc/BRIEF.md
# Data-Capture Wakeup-Select Issue Queue

This block is the waiting room between dispatch and execution in an out-of-order core. Each of its entries holds one operation: an opcode, a destination tag and two source operands. Each source carries its own tag, a captured value and a ready flag. When an operation is dispatched, any source that is already known arrives with its value and is marked ready. A missing source waits until a producer announces the matching tag on one of the result broadcast buses. The value on that bus is then copied into the entry, so that no register file read is needed when the operation leaves the queue.

A broadcast also carries the producer's remaining latency. A matching source latches the value at once but does not report ready until that many extra cycles have passed. A latency of zero wakes the source on the next cycle. An entry whose two sources are ready and that has not yet been sent bids for issue. A fixed lowest-index priority picks one bidder per cycle. The opcode, destination tag and both captured values of the chosen entry appear on registered issue outputs one cycle later. An entry that loses keeps bidding, and the chosen entry is released one cycle after its grant. New operations go into the lowest-numbered free entry. While all entries are occupied the queue reports full and ignores dispatch.

Top module: `iq_wakeup_select`

## Requirements
- R1: Reset leaves every entry empty: `q_full` is 0 and `iss_valid` is 0 until an operation has become ready.
- R2: A dispatch (`disp_valid`=1 while `q_full`=0) writes into the free entry with the lowest index, and that index is later reported on `iss_slot`. A source dispatched with its ready bit at 1 is ready from the next cycle, holding the dispatched value.
- R3: While `q_full` is 1 (all entries occupied), a dispatch is dropped: it never issues and it disturbs no stored entry.
- R4: On any broadcast bus with `bc_valid`=1, a tag equal to the tag of a waiting source in a valid entry causes the bus value to be captured. With latency 0 that source is ready on the next cycle, so the entry can be granted one cycle after the broadcast and appears on the issue outputs one cycle after that.
- R5: A broadcast latency L (field `bc_lat`, 0 to 2^LAT_W-1) delays the ready flag of a matching source by L cycles relative to latency 0. The value is still captured in the broadcast cycle.
- R6: An entry bids only when it is valid, has not been granted and has both sources ready. At most one bidder is granted per cycle, and it is the lowest index. A bidder that loses keeps bidding in later cycles.
- R7: In the cycle after a grant, `iss_valid` is 1. `iss_slot`, `iss_opcode`, `iss_dst`, `iss_l_val` and `iss_r_val` show the granted entry's index, opcode, destination tag and its two captured values.
- R8: A granted entry is released one cycle after its grant. From the cycle after that, it can accept a new dispatch.
- R9: If a dispatch and a matching broadcast name the same source tag in the same cycle, the broadcast value is stored, even when the dispatch marked that source ready. The broadcast's latency governs when the source becomes ready.
- R10: When several buses match the same waiting source in one cycle, the bus with the lowest index supplies the value and the latency.
- R11: A source that is already ready or counting down ignores later matching broadcasts, and its captured value is not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch an operation this cycle |
| disp_opcode | input | OP_W | Opcode of the dispatched operation |
| disp_dst | input | TAG_W | Destination tag of the dispatched operation |
| disp_l_tag | input | TAG_W | Left source tag |
| disp_l_val | input | DATA_W | Left source value (meaningful when ready) |
| disp_l_rdy | input | 1 | Left source already available |
| disp_r_tag | input | TAG_W | Right source tag |
| disp_r_val | input | DATA_W | Right source value (meaningful when ready) |
| disp_r_rdy | input | 1 | Right source already available |
| q_full | output | 1 | All entries occupied; dispatch is ignored |
| bc_valid | input | NBC | Per-bus broadcast strobe |
| bc_tag | input | NBC*TAG_W | Broadcast tags, bus b at bits [b*TAG_W +: TAG_W] |
| bc_val | input | NBC*DATA_W | Broadcast values, bus b at bits [b*DATA_W +: DATA_W] |
| bc_lat | input | NBC*LAT_W | Producer latency per bus, bus b at bits [b*LAT_W +: LAT_W] |
| iss_valid | output | 1 | An operation is issued this cycle |
| iss_slot | output | IDX_W | Entry index of the issued operation |
| iss_opcode | output | OP_W | Opcode of the issued operation |
| iss_dst | output | TAG_W | Destination tag of the issued operation |
| iss_l_val | output | DATA_W | Captured left operand value |
| iss_r_val | output | DATA_W | Captured right operand value |

## Verification
The sensitive overlap is a dispatch and a broadcast that carry the same source tag on the same clock edge. The write path and the capture path then both claim one operand slot. The bench provokes this with directed cases: a dispatched source marked not-ready, and one marked ready but with a different value, each meeting a broadcast of its tag in that cycle, once with zero and once with non-zero latency. It also leaves these collisions to happen freely under random traffic drawn from a small tag range. Each case is judged through the issue outputs. A cycle-by-cycle bench model predicts the issue cycle, the slot and both operand values, so a wrong winner or a wrong wakeup time shows up as a mismatch.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IQ_ENTRIES = 8;
  localparam int IQ_TAG_W   = 6;
  localparam int IQ_DATA_W  = 32;
  localparam int IQ_OP_W    = 8;
  localparam int IQ_NBC     = 2;
  localparam int IQ_LAT_W   = 2;
  localparam int IQ_SRCS    = 2;
endpackage

// File: rtl/iq_prio_pick.sv
module iq_prio_pick #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below[i] = below[i-1] | req[i-1];
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign gnt[i] = req[i] & ~below[i];
  end

  assert_single_pick_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_pick_has_req_R6: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
endmodule

// File: rtl/iq_operand.sv
module iq_operand #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 2,
  parameter int NBC    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alive,
  input  logic                         clr,
  input  logic                         wr,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [DATA_W-1:0]            wr_val,
  input  logic                         wr_rdy,
  input  logic [NBC-1:0]               bc_valid,
  input  logic [NBC-1:0][TAG_W-1:0]    bc_tag,
  input  logic [NBC-1:0][DATA_W-1:0]   bc_val,
  input  logic [NBC-1:0][LAT_W-1:0]    bc_lat,
  output logic                         rdy_o,
  output logic [DATA_W-1:0]            val_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              rdy_q;
  logic              pend_q;
  logic [LAT_W-1:0]  cnt_q;

  logic [TAG_W-1:0]  cmp_tag;
  logic              hit;
  logic [DATA_W-1:0] hit_val;
  logic [LAT_W-1:0]  hit_lat;
  logic              waiting;
  logic              take;

  always_comb begin
    cmp_tag = wr ? wr_tag : tag_q;
    hit     = 1'b0;
    hit_val = '0;
    hit_lat = '0;
    for (int b = NBC - 1; b >= 0; b--) begin
      if (bc_valid[b] && (bc_tag[b] == cmp_tag)) begin
        hit     = 1'b1;
        hit_val = bc_val[b];
        hit_lat = bc_lat[b];
      end
    end
    waiting = wr | (~rdy_q & ~pend_q);
    take    = waiting & hit & (alive | wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      val_q  <= '0;
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (take) begin
      tag_q <= cmp_tag;
      val_q <= hit_val;
      if (hit_lat == '0) begin
        rdy_q  <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        rdy_q  <= 1'b0;
        pend_q <= 1'b1;
        cnt_q  <= hit_lat;
      end
    end else if (wr) begin
      tag_q  <= wr_tag;
      val_q  <= wr_val;
      rdy_q  <= wr_rdy;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == LAT_W'(1)) begin
        rdy_q  <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - LAT_W'(1);
      end
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  assert_ready_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !clr && !wr) |=> rdy_q);
  assert_value_kept_R11: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !clr && !wr) |=> $stable(val_q));
  assert_pending_not_lost_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr && !wr) |=> (pend_q || rdy_q));
endmodule

// File: rtl/iq_entry.sv
module iq_entry #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8,
  parameter int LAT_W  = 2,
  parameter int NBC    = 2,
  parameter int SRCS   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic [OP_W-1:0]                 wr_op,
  input  logic [TAG_W-1:0]                wr_dst,
  input  logic [SRCS-1:0][TAG_W-1:0]      wr_tag,
  input  logic [SRCS-1:0][DATA_W-1:0]     wr_val,
  input  logic [SRCS-1:0]                 wr_rdy,
  input  logic [NBC-1:0]                  bc_valid,
  input  logic [NBC-1:0][TAG_W-1:0]       bc_tag,
  input  logic [NBC-1:0][DATA_W-1:0]      bc_val,
  input  logic [NBC-1:0][LAT_W-1:0]       bc_lat,
  input  logic                            grant,
  output logic                            valid_o,
  output logic                            bid_o,
  output logic [OP_W-1:0]                 op_o,
  output logic [TAG_W-1:0]                dst_o,
  output logic [SRCS-1:0][DATA_W-1:0]     src_val_o
);
  logic            valid_q;
  logic            issued_q;
  logic [OP_W-1:0] op_q;
  logic [TAG_W-1:0] dst_q;
  logic [SRCS-1:0] src_rdy;
  logic            release_now;

  assign release_now = valid_q & issued_q;

  for (genvar s = 0; s < SRCS; s++) begin : g_src
    iq_operand #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .LAT_W(LAT_W), .NBC(NBC)
    ) u_opnd (
      .clk      (clk),
      .rst      (rst),
      .alive    (valid_q),
      .clr      (release_now),
      .wr       (wr),
      .wr_tag   (wr_tag[s]),
      .wr_val   (wr_val[s]),
      .wr_rdy   (wr_rdy[s]),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .bc_lat   (bc_lat),
      .rdy_o    (src_rdy[s]),
      .val_o    (src_val_o[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      op_q     <= '0;
      dst_q    <= '0;
    end else if (release_now) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      if (grant) issued_q <= 1'b1;
      if (wr) begin
        valid_q <= 1'b1;
        op_q    <= wr_op;
        dst_q   <= wr_dst;
      end
    end
  end

  assign valid_o = valid_q;
  assign bid_o   = valid_q & ~issued_q & (&src_rdy);
  assign op_o    = op_q;
  assign dst_o   = dst_q;

  assert_issue_needs_bid_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(issued_q) |-> $past(bid_o));
  assert_release_next_R8: assert property (@(posedge clk) disable iff (rst)
    issued_q |=> !valid_q);
  assert_no_write_busy_R2: assert property (@(posedge clk) disable iff (rst)
    wr |-> !valid_q);
endmodule

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select
  import iq_pkg::*;
#(
  parameter int ENTRIES = IQ_ENTRIES,
  parameter int TAG_W   = IQ_TAG_W,
  parameter int DATA_W  = IQ_DATA_W,
  parameter int OP_W    = IQ_OP_W,
  parameter int NBC     = IQ_NBC,
  parameter int LAT_W   = IQ_LAT_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    disp_valid,
  input  logic [OP_W-1:0]         disp_opcode,
  input  logic [TAG_W-1:0]        disp_dst,
  input  logic [TAG_W-1:0]        disp_l_tag,
  input  logic [DATA_W-1:0]       disp_l_val,
  input  logic                    disp_l_rdy,
  input  logic [TAG_W-1:0]        disp_r_tag,
  input  logic [DATA_W-1:0]       disp_r_val,
  input  logic                    disp_r_rdy,
  output logic                    q_full,
  input  logic [NBC-1:0]          bc_valid,
  input  logic [NBC*TAG_W-1:0]    bc_tag,
  input  logic [NBC*DATA_W-1:0]   bc_val,
  input  logic [NBC*LAT_W-1:0]    bc_lat,
  output logic                    iss_valid,
  output logic [IDX_W-1:0]        iss_slot,
  output logic [OP_W-1:0]         iss_opcode,
  output logic [TAG_W-1:0]        iss_dst,
  output logic [DATA_W-1:0]       iss_l_val,
  output logic [DATA_W-1:0]       iss_r_val
);
  localparam int SRCS = IQ_SRCS;

  logic [NBC-1:0][TAG_W-1:0]   bc_tag_a;
  logic [NBC-1:0][DATA_W-1:0]  bc_val_a;
  logic [NBC-1:0][LAT_W-1:0]   bc_lat_a;
  logic [SRCS-1:0][TAG_W-1:0]  d_tag;
  logic [SRCS-1:0][DATA_W-1:0] d_val;
  logic [SRCS-1:0]             d_rdy;

  assign bc_tag_a = bc_tag;
  assign bc_val_a = bc_val;
  assign bc_lat_a = bc_lat;
  assign d_tag    = {disp_r_tag, disp_l_tag};
  assign d_val    = {disp_r_val, disp_l_val};
  assign d_rdy    = {disp_r_rdy, disp_l_rdy};

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] bid_vec;
  logic [ENTRIES-1:0] free_pick;
  logic [ENTRIES-1:0] wr_vec;
  logic [ENTRIES-1:0] gnt_vec;
  logic [OP_W-1:0]    e_op  [ENTRIES];
  logic [TAG_W-1:0]   e_dst [ENTRIES];
  logic [SRCS-1:0][DATA_W-1:0] e_val [ENTRIES];

  iq_prio_pick #(.N(ENTRIES)) u_alloc (
    .clk (clk), .rst (rst), .req (~valid_vec), .gnt (free_pick)
  );

  assign wr_vec = disp_valid ? free_pick : '0;
  assign q_full = &valid_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    iq_entry #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W),
      .LAT_W(LAT_W), .NBC(NBC), .SRCS(SRCS)
    ) u_ent (
      .clk       (clk),
      .rst       (rst),
      .wr        (wr_vec[i]),
      .wr_op     (disp_opcode),
      .wr_dst    (disp_dst),
      .wr_tag    (d_tag),
      .wr_val    (d_val),
      .wr_rdy    (d_rdy),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag_a),
      .bc_val    (bc_val_a),
      .bc_lat    (bc_lat_a),
      .grant     (gnt_vec[i]),
      .valid_o   (valid_vec[i]),
      .bid_o     (bid_vec[i]),
      .op_o      (e_op[i]),
      .dst_o     (e_dst[i]),
      .src_val_o (e_val[i])
    );
  end

  iq_prio_pick #(.N(ENTRIES)) u_select (
    .clk (clk), .rst (rst), .req (bid_vec), .gnt (gnt_vec)
  );

  logic [IDX_W-1:0]  sel_idx;
  logic [OP_W-1:0]   sel_op;
  logic [TAG_W-1:0]  sel_dst;
  logic [DATA_W-1:0] sel_l;
  logic [DATA_W-1:0] sel_r;

  always_comb begin
    sel_idx = '0;
    sel_op  = '0;
    sel_dst = '0;
    sel_l   = '0;
    sel_r   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (gnt_vec[i]) begin
        sel_idx = IDX_W'(i);
        sel_op  = e_op[i];
        sel_dst = e_dst[i];
        sel_l   = e_val[i][0];
        sel_r   = e_val[i][1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_slot   <= '0;
      iss_opcode <= '0;
      iss_dst    <= '0;
      iss_l_val  <= '0;
      iss_r_val  <= '0;
    end else begin
      iss_valid <= |gnt_vec;
      if (|gnt_vec) begin
        iss_slot   <= sel_idx;
        iss_opcode <= sel_op;
        iss_dst    <= sel_dst;
        iss_l_val  <= sel_l;
        iss_r_val  <= sel_r;
      end
    end
  end

  assert_full_drops_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
    (q_full && disp_valid) |-> (wr_vec == '0));
  assert_issue_follows_grant_R7: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(|bid_vec));
endmodule

// File: tb/iq_wakeup_select_tb_top.sv
module iq_wakeup_select_tb_top;
  localparam int NE = 8;
  localparam int TW = 6;
  localparam int DW = 32;
  localparam int OW = 8;
  localparam int NB = 2;
  localparam int LW = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          d_valid;
  logic [OW-1:0] d_op;
  logic [TW-1:0] d_dst;
  logic [TW-1:0] d_tag [2];
  logic [DW-1:0] d_val [2];
  logic          d_rdy [2];
  logic          b_v   [NB];
  logic [TW-1:0] b_tag [NB];
  logic [DW-1:0] b_val [NB];
  logic [LW-1:0] b_lat [NB];

  logic [NB-1:0]    bc_valid;
  logic [NB*TW-1:0] bc_tag;
  logic [NB*DW-1:0] bc_val;
  logic [NB*LW-1:0] bc_lat;
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bc_valid[b]          = b_v[b];
      bc_tag[b*TW +: TW]   = b_tag[b];
      bc_val[b*DW +: DW]   = b_val[b];
      bc_lat[b*LW +: LW]   = b_lat[b];
    end
  end

  logic          q_full, iss_valid;
  logic [IW-1:0] iss_slot;
  logic [OW-1:0] iss_opcode;
  logic [TW-1:0] iss_dst;
  logic [DW-1:0] iss_l_val, iss_r_val;

  iq_wakeup_select dut_i (
    .clk(clk), .rst(rst),
    .disp_valid(d_valid), .disp_opcode(d_op), .disp_dst(d_dst),
    .disp_l_tag(d_tag[0]), .disp_l_val(d_val[0]), .disp_l_rdy(d_rdy[0]),
    .disp_r_tag(d_tag[1]), .disp_r_val(d_val[1]), .disp_r_rdy(d_rdy[1]),
    .q_full(q_full),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .bc_lat(bc_lat),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_opcode(iss_opcode),
    .iss_dst(iss_dst), .iss_l_val(iss_l_val), .iss_r_val(iss_r_val)
  );

  // bench model of the queue, built from the requirements
  logic          m_v [NE];
  logic          m_iss [NE];
  logic [OW-1:0] m_op [NE];
  logic [TW-1:0] m_dst [NE];
  logic [TW-1:0] m_tag [NE][2];
  logic [DW-1:0] m_val [NE][2];
  logic          m_rdy [NE][2];
  logic          m_pend [NE][2];
  logic [LW-1:0] m_cnt [NE][2];

  logic          e_iv;
  logic [IW-1:0] e_slot;
  logic [OW-1:0] e_op;
  logic [TW-1:0] e_dst;
  logic [DW-1:0] e_l, e_r;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1";

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_iss[i] = 0; m_op[i] = '0; m_dst[i] = '0;
      for (int s = 0; s < 2; s++) begin
        m_tag[i][s] = '0; m_val[i][s] = '0; m_rdy[i][s] = 0;
        m_pend[i][s] = 0; m_cnt[i][s] = '0;
      end
    end
    e_iv = 0; e_slot = '0; e_op = '0; e_dst = '0; e_l = '0; e_r = '0;
  endtask

  function automatic bit full_now();
    bit f = 1;
    for (int i = 0; i < NE; i++) if (!m_v[i]) f = 0;
    return f;
  endfunction

  task automatic model_step();
    int g = -1;
    int a = -1;
    for (int i = 0; i < NE; i++)
      if (g < 0 && m_v[i] && !m_iss[i] && m_rdy[i][0] && m_rdy[i][1]) g = i;
    if (g >= 0) begin
      e_iv = 1; e_slot = IW'(g); e_op = m_op[g]; e_dst = m_dst[g];
      e_l = m_val[g][0]; e_r = m_val[g][1];
    end else e_iv = 0;
    if (d_valid) for (int i = 0; i < NE; i++) if (a < 0 && !m_v[i]) a = i;
    for (int i = 0; i < NE; i++) begin
      if (m_v[i] && m_iss[i]) begin
        m_v[i] = 0; m_iss[i] = 0;
        for (int s = 0; s < 2; s++) begin m_rdy[i][s] = 0; m_pend[i][s] = 0; end
      end else begin
        for (int s = 0; s < 2; s++) begin
          bit wr = (i == a);
          logic [TW-1:0] tg = wr ? d_tag[s] : m_tag[i][s];
          bit hit = 0;
          logic [DW-1:0] hv = '0;
          logic [LW-1:0] hl = '0;
          bit take;
          for (int b = NB - 1; b >= 0; b--)
            if (b_v[b] && b_tag[b] == tg) begin hit = 1; hv = b_val[b]; hl = b_lat[b]; end
          take = (wr || (!m_rdy[i][s] && !m_pend[i][s])) && hit && (m_v[i] || wr);
          if (take) begin
            m_tag[i][s] = tg; m_val[i][s] = hv;
            if (hl == 0) begin m_rdy[i][s] = 1; m_pend[i][s] = 0; end
            else begin m_rdy[i][s] = 0; m_pend[i][s] = 1; m_cnt[i][s] = hl; end
          end else if (wr) begin
            m_tag[i][s] = d_tag[s]; m_val[i][s] = d_val[s];
            m_rdy[i][s] = d_rdy[s]; m_pend[i][s] = 0;
          end else if (m_pend[i][s]) begin
            if (m_cnt[i][s] == 1) begin m_rdy[i][s] = 1; m_pend[i][s] = 0; end
            else m_cnt[i][s] = m_cnt[i][s] - 1;
          end
        end
        if (i == g) m_iss[i] = 1;
        if (i == a) begin m_v[i] = 1; m_op[i] = d_op; m_dst[i] = d_dst; end
      end
    end
  endtask

  task automatic idle_inputs();
    d_valid = 0; d_op = '0; d_dst = '0;
    for (int s = 0; s < 2; s++) begin d_tag[s] = '0; d_val[s] = '0; d_rdy[s] = 0; end
    for (int b = 0; b < NB; b++) begin b_v[b] = 0; b_tag[b] = '0; b_val[b] = '0; b_lat[b] = '0; end
  endtask

  // one clock: predict, advance, compare at the falling edge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(iss_valid == e_iv, phase, "iss_valid", longint'(iss_valid), longint'(e_iv));
    if (e_iv && iss_valid) begin
      chk(iss_slot == e_slot, phase, "iss_slot", longint'(iss_slot), longint'(e_slot));
      chk(iss_opcode == e_op, phase, "iss_opcode", longint'(iss_opcode), longint'(e_op));
      chk(iss_dst == e_dst, phase, "iss_dst", longint'(iss_dst), longint'(e_dst));
      chk(iss_l_val == e_l, phase, "iss_l_val", longint'(iss_l_val), longint'(e_l));
      chk(iss_r_val == e_r, phase, "iss_r_val", longint'(iss_r_val), longint'(e_r));
    end
    chk(q_full == full_now(), phase, "q_full", longint'(q_full), longint'(full_now()));
    idle_inputs();
  endtask

  task automatic disp(input logic [OW-1:0] op, input logic [TW-1:0] lt, input logic lr,
                      input logic [DW-1:0] lv, input logic [TW-1:0] rt, input logic rr,
                      input logic [DW-1:0] rv);
    d_valid = 1; d_op = op; d_dst = TW'(op);
    d_tag[0] = lt; d_rdy[0] = lr; d_val[0] = lv;
    d_tag[1] = rt; d_rdy[1] = rr; d_val[1] = rv;
  endtask

  task automatic bcast(input int b, input logic [TW-1:0] t, input logic [DW-1:0] v,
                       input logic [LW-1:0] l);
    b_v[b] = 1; b_tag[b] = t; b_val[b] = v; b_lat[b] = l;
  endtask

  task automatic drain();
    for (int k = 0; k < 32; k++) begin
      bcast(0, TW'(2 * k), 32'hD000_0000 + k, '0);
      bcast(1, TW'(2 * k + 1), 32'hD100_0000 + k, '0);
      tick();
    end
    repeat (12) tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1A2B_3C4D);
    idle_inputs();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(q_full == 0, "R1", "q_full after reset", longint'(q_full), 0);
    chk(iss_valid == 0, "R1", "iss_valid after reset", longint'(iss_valid), 0);
    phase = "R1";
    repeat (2) tick();

    // R2: ready ops land in lowest free slots and issue in order
    phase = "R2";
    disp(8'h11, 6'd1, 1, 32'hA1, 6'd2, 1, 32'hB1); tick();
    disp(8'h12, 6'd1, 1, 32'hA2, 6'd2, 1, 32'hB2); tick();
    disp(8'h13, 6'd1, 1, 32'hA3, 6'd2, 1, 32'hB3); tick();
    repeat (5) tick();

    // R4: wake by broadcast with zero latency, on each bus
    phase = "R4";
    disp(8'h21, 6'd40, 0, 32'h0, 6'd41, 1, 32'h77); tick();
    disp(8'h22, 6'd42, 1, 32'h55, 6'd43, 0, 32'h0); tick();
    bcast(0, 6'd40, 32'hCAFE_0040, 2'd0); bcast(1, 6'd43, 32'hCAFE_0043, 2'd0); tick();
    repeat (4) tick();

    // R5: delayed wakeup, each latency
    phase = "R5";
    for (int l = 1; l < 4; l++) begin
      disp(OW'(8'h30 + l), 6'd44, 0, 32'h0, 6'd45, 1, 32'h99); tick();
      bcast(1, 6'd44, 32'hBEEF_0000 + l, LW'(l)); tick();
      repeat (6) tick();
    end

    // R6: several ready at once, lowest index first, losers retry
    phase = "R6";
    for (int k = 0; k < 4; k++) begin
      disp(OW'(8'h40 + k), 6'd46, 0, 32'h0, 6'd47, 1, 32'h100 + k); tick();
    end
    bcast(0, 6'd46, 32'h4646_4646, 2'd0); tick();
    repeat (6) tick();

    // R3: fill, then a dropped dispatch
    phase = "R3";
    for (int k = 0; k < NE; k++) begin
      disp(OW'(8'h50 + k), 6'd60, 0, 32'h0, 6'd61, 1, 32'h500 + k); tick();
    end
    chk(q_full == 1, "R3", "q_full when all occupied", longint'(q_full), 1);
    disp(8'hEE, 6'd1, 1, 32'hEEEE, 6'd2, 1, 32'hEEEE); tick();
    repeat (3) tick();
    chk(iss_valid == 0, "R3", "dropped op never issues", longint'(iss_valid), 0);
    bcast(1, 6'd60, 32'h6060_6060, 2'd0); tick();
    repeat (12) tick();

    // R8: release then immediate reuse of the freed slot
    phase = "R8";
    disp(8'h61, 6'd3, 1, 32'h61, 6'd4, 1, 32'h62); tick();
    repeat (2) tick();
    disp(8'h62, 6'd3, 1, 32'h63, 6'd4, 1, 32'h64); tick();
    repeat (3) tick();

    // R9: dispatch and broadcast of the same tag in one cycle
    phase = "R9";
    disp(8'h71, 6'd50, 0, 32'h0, 6'd51, 1, 32'h71);
    bcast(0, 6'd50, 32'h9999_0001, 2'd0); tick();
    disp(8'h72, 6'd52, 1, 32'h1111, 6'd53, 1, 32'h72);
    bcast(1, 6'd52, 32'h9999_0002, 2'd2); tick();
    repeat (6) tick();

    // R10: both buses hit one source, lowest bus wins
    phase = "R10";
    disp(8'h81, 6'd54, 0, 32'h0, 6'd55, 1, 32'h81); tick();
    bcast(0, 6'd54, 32'hAAAA_0000, 2'd0); bcast(1, 6'd54, 32'hBBBB_0000, 2'd3); tick();
    repeat (4) tick();

    // R11: later broadcasts do not touch ready or counting sources
    phase = "R11";
    disp(8'h91, 6'd56, 0, 32'h0, 6'd57, 0, 32'h0); tick();
    bcast(0, 6'd56, 32'h5656_0001, 2'd3); tick();
    bcast(0, 6'd56, 32'h5656_0002, 2'd0); tick();
    bcast(1, 6'd57, 32'h5757_0001, 2'd0); tick();
    bcast(1, 6'd57, 32'h5757_0002, 2'd0); tick();
    repeat (6) tick();
    drain();

    // R7: random traffic, every issue compared field by field
    phase = "R7";
    for (int c = 0; c < 2000; c++) begin
      if ($urandom_range(1, 0) == 1) begin
        disp(OW'($urandom), TW'($urandom_range(15, 0)), logic'($urandom_range(1, 0)),
             $urandom, TW'($urandom_range(15, 0)), logic'($urandom_range(1, 0)), $urandom);
      end
      for (int b = 0; b < NB; b++)
        if ($urandom_range(9, 0) < 4)
          bcast(b, TW'($urandom_range(15, 0)), $urandom, LW'($urandom_range(3, 0)));
      tick();
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule